// File: doc/BRIEF.md
# Hysteretic Peak/Hold Current Controller

This block is the digital core of a solenoid driver that regulates load current with a two-level bang-bang loop. A control cycle is open while both the enable input and the control input are high, and it closes as soon as either of them falls. Inside the cycle the block holds a level state, high or low. The reference code sent to an external DAC is the high or low code of the active code pair. An external comparator reports whether the load current is below that reference. The block then switches the gate-drive request and the clamp request with hysteresis: it charges the load up to the high reference and lets it decay to the low reference.

A phase input from a separate dwell timer selects which pair is active. Peak phase uses the larger start-up pair and hold phase uses the smaller sustaining pair. A phase change takes effect at once and keeps the present level. An open-load flag is gathered during the cycle. It is reported as a one-clock capture strobe at the clock edge that closes the cycle, so that a serial register outside the block can take the fault.

The reset is asynchronous and active low. Its release is synchronised inside the block with two flops, so the logic leaves reset on the second rising clock edge after the reset pin goes high.

Top module: `hpc_ctrl`

## Requirements
- R1: A cycle opens on the first rising edge at which `en_i` and `ctl_i` are both sampled high; `gate_o` is then 1 after that edge. The cycle closes on the first edge at which either input is sampled low; after that edge `gate_o` and `clamp_o` are both 0.
- R2: The first edge of a cycle always sets the high level, whatever the comparator shows. `dac_code_o` is then `pk_hi_i` when `hold_i`=0 (peak) and `hd_hi_i` when `hold_i`=1 (hold).
- R3: In the high level with `below_i`=1 (current below reference), the state does not change: `gate_o`=1, `clamp_o`=0 and the DAC shows the high code.
- R4: In the high level, an edge with `below_i`=0 moves to the low level: `gate_o`=0, `clamp_o`=1, and `dac_code_o` becomes the low code of the active pair (`pk_lo_i` or `hd_lo_i`).
- R5: In the low level, `below_i`=0 keeps the low level. An edge with `below_i`=1 returns to the high level: `gate_o`=1, `clamp_o`=0, and the DAC shows the high code.
- R6: `dac_code_o` follows `hold_i` in the same clock. A change from peak to hold (or back) swaps the pair and keeps the level that is active: the high level shows pk_hi to hd_hi, the low level shows pk_lo to hd_lo.
- R7: `gate_o` and `clamp_o` are never 1 together. Both are 0 outside a cycle and while reset is held. Outside a cycle `dac_code_o` shows the high code of the selected phase.
- R8: `loop_o` is the inverse of `below_i` as sampled on the previous rising edge (1 means current at or above the reference). It is 0 during reset.
- R9: `ol_cap_o` is 1 for exactly the one clock after the edge that closes a cycle, and only if `open_load_i` was sampled 1 on at least one edge inside that cycle (the opening edge included). When `open_load_i` is high while no cycle is open, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable qualifier |
| ctl_i | input | 1 | Control request |
| hold_i | input | 1 | Dwell phase: 0 peak, 1 hold |
| below_i | input | 1 | Comparator: 1 when load current is below the DAC reference |
| open_load_i | input | 1 | Open-load detect flag |
| pk_hi_i | input | CODE_W | Peak high reference code |
| pk_lo_i | input | CODE_W | Peak low reference code |
| hd_hi_i | input | CODE_W | Hold high reference code |
| hd_lo_i | input | CODE_W | Hold low reference code |
| dac_code_o | output | CODE_W | Reference code to the DAC |
| gate_o | output | 1 | Gate-on request |
| clamp_o | output | 1 | Clamp-on request |
| loop_o | output | 1 | Loop status, low when current is below reference |
| ol_cap_o | output | 1 | Open-load capture strobe |

## Verification
The comparator is driven with several patterns. A steady below-reference input shows that the high level holds. A single crossing shows the move to the low level, and a held above-reference input shows that the low level does not fall back on its own. A sequence of alternating crossings shows the full hysteresis. The phase input is toggled while the low and high levels are active, which tells a pair swap apart from a level change. A start with the comparator already above reference shows that the opening edge always sets the high level. Cycles with and without a latched fault, together with an open-load flag raised while idle, separate a real capture from a spurious one. A reset asserted in the middle of a cycle checks the forced-off outputs and the two-clock release.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } level_e;

  typedef enum logic {
    PH_PEAK = 1'b0,
    PH_HOLD = 1'b1
  } phase_e;

endpackage

// File: rtl/hpc_rst_sync.sv
module hpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_q_n = sync_q;

endmodule

// File: rtl/hpc_cycle_seq.sv
module hpc_cycle_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ctl_i,
  output logic active_o,
  output logic in_cycle_o,
  output logic start_o,
  output logic stop_o
);

  logic in_cycle_q;
  logic in_cycle_d;
  logic active;

  assign active = en_i & ctl_i;

  always_comb begin
    in_cycle_d = active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cycle_q <= 1'b0;
    end else begin
      in_cycle_q <= in_cycle_d;
    end
  end

  assign active_o   = active;
  assign in_cycle_o = in_cycle_q;
  assign start_o    = active & ~in_cycle_q;
  assign stop_o     = ~active & in_cycle_q;

endmodule

// File: rtl/hpc_hyst_loop.sv
module hpc_hyst_loop
  import hpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   active_i,
  input  logic   in_cycle_i,
  input  logic   start_i,
  input  logic   below_i,
  output level_e level_o,
  output logic   gate_o,
  output logic   clamp_o,
  output logic   loop_o
);

  level_e level_q;
  level_e level_d;
  logic   level_en;
  logic   loop_q;

  always_comb begin
    level_d  = level_q;
    level_en = 1'b0;
    if (!active_i) begin
      level_d  = LVL_HIGH;
      level_en = (level_q != LVL_HIGH);
    end else if (start_i) begin
      level_d  = LVL_HIGH;
      level_en = 1'b1;
    end else if (in_cycle_i) begin
      unique case (level_q)
        LVL_HIGH: if (!below_i) begin
          level_d  = LVL_LOW;
          level_en = 1'b1;
        end
        LVL_LOW: if (below_i) begin
          level_d  = LVL_HIGH;
          level_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LVL_HIGH;
    end else if (level_en) begin
      level_q <= level_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0;
    end else begin
      loop_q <= ~below_i;
    end
  end

  assign level_o = level_q;
  assign gate_o  = in_cycle_i & (level_q == LVL_HIGH);
  assign clamp_o = in_cycle_i & (level_q == LVL_LOW);
  assign loop_o  = loop_q;

endmodule

// File: rtl/hpc_ref_select.sv
module hpc_ref_select
  import hpc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  phase_e              phase_i,
  input  level_e              level_i,
  input  logic [CODE_W-1:0]   pk_hi_i,
  input  logic [CODE_W-1:0]   pk_lo_i,
  input  logic [CODE_W-1:0]   hd_hi_i,
  input  logic [CODE_W-1:0]   hd_lo_i,
  output logic [CODE_W-1:0]   code_o
);

  localparam int NUM_REFS = 4;

  logic [CODE_W-1:0] refs [NUM_REFS];
  logic [1:0]        sel;

  assign refs[0] = pk_lo_i;
  assign refs[1] = pk_hi_i;
  assign refs[2] = hd_lo_i;
  assign refs[3] = hd_hi_i;

  assign sel    = {phase_i == PH_HOLD, level_i == LVL_HIGH};
  assign code_o = refs[sel];

endmodule

// File: rtl/hpc_fault_latch.sv
module hpc_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic in_cycle_i,
  input  logic stop_i,
  input  logic open_load_i,
  output logic cap_o
);

  logic flag_q;
  logic flag_d;
  logic cap_q;
  logic cap_d;

  always_comb begin
    flag_d = 1'b0;
    if (active_i) begin
      flag_d = (in_cycle_i & flag_q) | open_load_i;
    end
    cap_d = stop_i & flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      cap_q  <= cap_d;
    end
  end

  assign cap_o = cap_q;

endmodule

// File: rtl/hpc_ctrl.sv
module hpc_ctrl
  import hpc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              ctl_i,
  input  logic              hold_i,
  input  logic              below_i,
  input  logic              open_load_i,
  input  logic [CODE_W-1:0] pk_hi_i,
  input  logic [CODE_W-1:0] pk_lo_i,
  input  logic [CODE_W-1:0] hd_hi_i,
  input  logic [CODE_W-1:0] hd_lo_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              gate_o,
  output logic              clamp_o,
  output logic              loop_o,
  output logic              ol_cap_o
);

  logic   rst_q_n;
  logic   active;
  logic   in_cycle;
  logic   start;
  logic   stop;
  level_e level;
  phase_e phase;

  assign phase = hold_i ? PH_HOLD : PH_PEAK;

  hpc_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  hpc_cycle_seq i_cycle_seq (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .en_i       (en_i),
    .ctl_i      (ctl_i),
    .active_o   (active),
    .in_cycle_o (in_cycle),
    .start_o    (start),
    .stop_o     (stop)
  );

  hpc_hyst_loop i_hyst_loop (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .active_i   (active),
    .in_cycle_i (in_cycle),
    .start_i    (start),
    .below_i    (below_i),
    .level_o    (level),
    .gate_o     (gate_o),
    .clamp_o    (clamp_o),
    .loop_o     (loop_o)
  );

  hpc_ref_select #(
    .CODE_W (CODE_W)
  ) i_ref_select (
    .phase_i (phase),
    .level_i (level),
    .pk_hi_i (pk_hi_i),
    .pk_lo_i (pk_lo_i),
    .hd_hi_i (hd_hi_i),
    .hd_lo_i (hd_lo_i),
    .code_o  (dac_code_o)
  );

  hpc_fault_latch i_fault_latch (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .active_i    (active),
    .in_cycle_i  (in_cycle),
    .stop_i      (stop),
    .open_load_i (open_load_i),
    .cap_o       (ol_cap_o)
  );

endmodule

// File: rtl/hpc_ctrl_chk.sv
module hpc_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              ctl_i,
  input logic              hold_i,
  input logic              below_i,
  input logic [CODE_W-1:0] pk_hi_i,
  input logic [CODE_W-1:0] hd_hi_i,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              gate_o,
  input logic              clamp_o,
  input logic              loop_o,
  input logic              ol_cap_o
);

  always_comb begin
    if (rst_n) begin
      AST_NO_OVERLAP: assert (!(gate_o && clamp_o)); // R7
    end
  end

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && ctl_i) |=> !gate_o && !clamp_o); // R1

  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && ctl_i && !gate_o && !clamp_o) |=> gate_o); // R2

  AST_HI_TO_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && en_i && ctl_i && !below_i) |=> clamp_o); // R4

  AST_LO_TO_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_o && en_i && ctl_i && below_i) |=> gate_o); // R5

  AST_HIGH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> dac_code_o == (hold_i ? hd_hi_i : pk_hi_i)); // R6

  AST_LOOP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) or 1'b1 |=> loop_o == !$past(below_i)); // R8

  AST_CAP_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ol_cap_o |-> !gate_o && !clamp_o); // R9

  AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ol_cap_o |=> !ol_cap_o); // R9

endmodule

bind hpc_ctrl hpc_ctrl_chk #(
  .CODE_W (CODE_W)
) i_hpc_ctrl_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .en_i       (en_i),
  .ctl_i      (ctl_i),
  .hold_i     (hold_i),
  .below_i    (below_i),
  .pk_hi_i    (pk_hi_i),
  .hd_hi_i    (hd_hi_i),
  .dac_code_o (dac_code_o),
  .gate_o     (gate_o),
  .clamp_o    (clamp_o),
  .loop_o     (loop_o),
  .ol_cap_o   (ol_cap_o)
);

// File: tb/test_hpc_ctrl.sv
module test_hpc_ctrl;

  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] C_PK_HI = 8'hC8;
  localparam logic [CODE_W-1:0] C_PK_LO = 8'hB4;
  localparam logic [CODE_W-1:0] C_HD_HI = 8'h64;
  localparam logic [CODE_W-1:0] C_HD_LO = 8'h50;

  // {en, ctl, hold, below, open_load, exp_gate, exp_clamp, exp_cap, exp_loop, dac_sel[1:0]}
  // dac_sel: 0 pk_hi, 1 pk_lo, 2 hd_hi, 3 hd_lo
  localparam int NV = 19;
  localparam logic [10:0] VEC [NV] = '{
    11'b00010_0000_00, // idle (R7)
    11'b11010_1000_00, // open, peak high (R1 R2)
    11'b11010_1000_00, // below high: hold level (R3)
    11'b11000_0101_01, // cross high -> low (R4)
    11'b11000_0101_01, // stay low (R5)
    11'b11010_1000_00, // below low -> high (R5)
    11'b11000_0101_01, // -> low again (R4)
    11'b11100_0101_11, // phase to hold keeps low level (R6)
    11'b11111_1000_10, // -> high in hold, fault seen (R5 R9)
    11'b11100_0101_11, // -> low in hold (R4)
    11'b01100_0011_10, // close with fault: strobe (R1 R9)
    11'b01100_0001_10, // idle, strobe gone (R9)
    11'b10011_0000_00, // open-load while idle ignored (R9)
    11'b11110_1000_10, // open in hold phase (R2)
    11'b10110_0000_10, // close without fault (R9)
    11'b00010_0000_00, // idle (R7)
    11'b11000_1001_00, // opening edge forces high (R2)
    11'b11000_0101_01, // then low (R4)
    11'b01000_0001_00  // close (R1)
  };

  logic              clk;
  logic              rst_n;
  logic              en_i, ctl_i, hold_i, below_i, open_load_i;
  logic [CODE_W-1:0] dac_code_o;
  logic              gate_o, clamp_o, loop_o, ol_cap_o;

  int checks;
  int errors;
  bit done;

  hpc_ctrl #(.CODE_W(CODE_W)) i_hpc_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .ctl_i       (ctl_i),
    .hold_i      (hold_i),
    .below_i     (below_i),
    .open_load_i (open_load_i),
    .pk_hi_i     (C_PK_HI),
    .pk_lo_i     (C_PK_LO),
    .hd_hi_i     (C_HD_HI),
    .hd_lo_i     (C_HD_LO),
    .dac_code_o  (dac_code_o),
    .gate_o      (gate_o),
    .clamp_o     (clamp_o),
    .loop_o      (loop_o),
    .ol_cap_o    (ol_cap_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [CODE_W-1:0] code_of(input logic [1:0] sel);
    case (sel)
      2'd0: return C_PK_HI;
      2'd1: return C_PK_LO;
      2'd2: return C_HD_HI;
      default: return C_HD_LO;
    endcase
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [4:0] v);
    {en_i, ctl_i, hold_i, below_i, open_load_i} = v;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    drive(5'b00010);
    repeat (3) step();
    // R7 R8 reset state
    chk("R7 reset gate", gate_o, 0);
    chk("R7 reset clamp", clamp_o, 0);
    chk("R8 reset loop", loop_o, 0);
    chk("R9 reset strobe", ol_cap_o, 0);
    chk("R7 reset dac", dac_code_o, C_PK_HI);
    rst_n = 1'b1;
    repeat (3) step();

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10:6]);
      step();
      chk($sformatf("vec %0d gate R1/R3/R4/R5", i), gate_o, VEC[i][5]);
      chk($sformatf("vec %0d clamp R4/R5/R7", i), clamp_o, VEC[i][4]);
      chk($sformatf("vec %0d strobe R9", i), ol_cap_o, VEC[i][3]);
      chk($sformatf("vec %0d loop R8", i), loop_o, VEC[i][2]);
      chk($sformatf("vec %0d dac R2/R6", i), dac_code_o, code_of(VEC[i][1:0]));
    end

    // R6: phase swap in the high level, same clock
    drive(5'b11010);
    step();
    chk("R6 peak high", dac_code_o, C_PK_HI);
    #2 hold_i = 1'b1;
    #1 chk("R6 swap to hold high", dac_code_o, C_HD_HI);
    chk("R6 swap keeps gate", gate_o, 1);

    // R7: reset mid-cycle forces outputs off, two-edge release
    #2 rst_n = 1'b0;
    #1 chk("R7 async reset gate", gate_o, 0);
    chk("R7 async reset clamp", clamp_o, 0);
    step();
    rst_n = 1'b1;
    step();
    step();
    chk("R1 still held by release sync", gate_o, 0);
    step();
    chk("R1 open after release", gate_o, 1);
    drive(5'b00010);
    step();
    chk("R1 closed", gate_o, 0);
    chk("R9 no fault no strobe", ol_cap_o, 0);

    // R9: fault seen on the opening edge only
    drive(5'b11011);
    step();
    drive(5'b11010);
    step();
    drive(5'b10010);
    step();
    chk("R9 fault on opening edge", ol_cap_o, 1);
    step();
    chk("R9 strobe single", ol_cap_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule